// File: doc/BRIEF.md
# Variable-Tap Serial Delay Line

This block delays a one-bit serial stream by a number of clock cycles chosen at run time. It is built from chained units of 32 storage stages each. Every enabled clock edge moves the data one stage down the line. A tap address picks the stage that drives the output, so a stage index of `a` gives a delay of `a + 1` cycles. The tap multiplexer is purely combinational: when the address changes, the output follows without waiting for a clock edge.

With the default of four chained units the line is 128 stages long. A 7-bit tap address reaches every stage. Its two upper bits choose the unit and its five lower bits choose the stage within that unit. The output of the last stage is brought out as a cascade output, so a further line can be attached. The storage has no reset and cannot be loaded in parallel. Its power-up contents come from an initial-value parameter, and data only enters and leaves serially.

A fixed address turns the block into a constant delay line. For example, to line up a 64-bit path that is 17 cycles short of a parallel branch, 64 copies can be used, each with the address held at 16. An address that changes while the line runs makes it an elastic buffer.

Top module: `vardelay_line`

## Requirements
- R1: With the clock enable high on every edge and the tap address held at 0, `tap_out` equals the `din` value sampled at the most recent clock edge, which is a delay of one cycle.
- R2: A change of `tap_addr` changes `tap_out` within the same clock cycle, with no clock edge in between, to the stage that the new address selects.
- R3: While `en` is low, a clock edge moves no data. With the address held, `tap_out` and `casc_out` keep their values across the edge. Once `en` is high again, shifting continues from the held contents.
- R4: `casc_out` is the content of the last stage of the last unit. With the default four units, it carries the `din` bit sampled 128 enabled edges earlier.
- R5: Bits [6:5] of `tap_addr` select the unit (0 is nearest the input) and bits [4:0] select the stage within it. Address `A` therefore yields the `din` bit from `A + 1` enabled edges earlier, and this holds across unit boundaries.
- R6: With `tap_addr` held at a constant value `A`, the delay is `A + 1` cycles on every cycle of a continuous stream.
- R7: The delay limits are one cycle at address 0 and 128 cycles at address 127.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; data moves on the rising edge |
| en | input | 1 | Clock enable, active high; when low, all stages hold |
| din | input | 1 | Serial data into stage 0 |
| tap_addr | input | 7 | Stage index read by `tap_out` (unit in [6:5], stage in [4:0]) |
| tap_out | output | 1 | Combinational read of the addressed stage |
| casc_out | output | 1 | Content of the final stage, for chaining |

## Verification
On every cycle, the assertions check four things:
- an enabled edge at address 0 puts the last input on the tap;
- stage `a` moves to stage `a + 1` on an enabled edge, at every unit boundary included;
- the stage just before the last moves into the cascade output;
- an idle edge disturbs neither the tap nor the cascade output.

Only the bench's scenarios can show other behaviours. These are that an address change shows up between clock edges, and that the delay over a long stream stays fixed. The bench also shows the two limits of 1 and 128 cycles, and the resumption of a stream after an idle stretch. The bench checks only stages that have already been shifted into.

// File: rtl/vdl_pkg.sv
package vdl_pkg;

    // Default geometry of one storage unit and of the chained line
    localparam int DEF_UNIT_STAGES = 32;
    localparam int DEF_UNITS       = 4;
    localparam int MAX_UNITS       = 4;

    // Width of a tap address for a given geometry
    function automatic int addr_width(input int stages, input int units);
        return $clog2(stages * units);
    endfunction

endpackage

// File: rtl/vdl_stage_chain.sv
module vdl_stage_chain #(
    parameter int   STAGES   = vdl_pkg::DEF_UNIT_STAGES,
    parameter logic INIT_BIT = 1'b0,
    localparam int  SW       = $clog2(STAGES)
) (
    input  logic          clk,
    input  logic          en,
    input  logic          din,
    input  logic [SW-1:0] tap_sel,
    output logic          tap,
    output logic          last
);

    typedef struct packed {
        logic [STAGES-1:0] stg;
    } chain_st_t;

    chain_st_t chain_d;
    chain_st_t chain_q = '{stg: {STAGES{INIT_BIT}}};

    // Next state: shift toward the high index when enabled, else hold
    always_comb begin
        chain_d = chain_q;
        if (en) begin
            chain_d.stg = {chain_q.stg[STAGES-2:0], din};
        end
    end

    always_ff @(posedge clk) begin
        chain_q <= chain_d;
    end

    // Live tap read and the final-stage output
    assign tap  = chain_q.stg[tap_sel];
    assign last = chain_q.stg[STAGES-1];

endmodule

// File: rtl/vdl_unit_sel.sv
module vdl_unit_sel #(
    parameter int  UNITS = vdl_pkg::DEF_UNITS,
    localparam int SELW  = (UNITS > 1) ? $clog2(UNITS) : 1
) (
    input  logic [UNITS-1:0] taps,
    input  logic [SELW-1:0]  sel,
    output logic             pick
);

    always_comb begin
        pick = 1'b0;
        for (int i = 0; i < UNITS; i++) begin
            if (sel == SELW'(i)) begin
                pick = taps[i];
            end
        end
    end

endmodule

// File: rtl/vardelay_line.sv
module vardelay_line #(
    parameter int   UNIT_STAGES = vdl_pkg::DEF_UNIT_STAGES,
    parameter int   UNITS       = vdl_pkg::DEF_UNITS,
    parameter logic INIT_BIT    = 1'b0,
    localparam int  TOTAL       = UNIT_STAGES * UNITS,
    localparam int  ADDR_W      = vdl_pkg::addr_width(UNIT_STAGES, UNITS),
    localparam int  UNIT_AW     = $clog2(UNIT_STAGES)
) (
    input  logic              clk,
    input  logic              en,
    input  logic              din,
    input  logic [ADDR_W-1:0] tap_addr,
    output logic              tap_out,
    output logic              casc_out
);

    logic [UNITS:0]   link;
    logic [UNITS-1:0] unit_tap;

    assign link[0] = din;

    // One storage unit per slot, each fed by the final stage of the one before
    for (genvar g = 0; g < UNITS; g++) begin : g_unit
        vdl_stage_chain #(
            .STAGES  (UNIT_STAGES),
            .INIT_BIT(INIT_BIT)
        ) u_chain (
            .clk    (clk),
            .en     (en),
            .din    (link[g]),
            .tap_sel(tap_addr[UNIT_AW-1:0]),
            .tap    (unit_tap[g]),
            .last   (link[g+1])
        );
    end

    // Upper address bits choose which unit's tap reaches the output
    if (UNITS > 1) begin : g_multi
        vdl_unit_sel #(
            .UNITS(UNITS)
        ) u_sel (
            .taps(unit_tap),
            .sel (tap_addr[ADDR_W-1:UNIT_AW]),
            .pick(tap_out)
        );
    end else begin : g_single
        assign tap_out = unit_tap[0];
    end

    assign casc_out = link[UNITS];

endmodule

// File: rtl/vdl_chk.sv
module vdl_chk #(
    parameter int ADDR_W = 7,
    parameter int TOTAL  = 128
) (
    input logic              clk,
    input logic              en,
    input logic              din,
    input logic [ADDR_W-1:0] tap_addr,
    input logic              tap_out,
    input logic              casc_out
);

    // No reset exists; checks start after the first edge
    logic armed = 1'b0;
    always_ff @(posedge clk) armed <= 1'b1;

    localparam logic [ADDR_W-1:0] TOP_A  = ADDR_W'(TOTAL - 1);
    localparam logic [ADDR_W-1:0] PREV_A = ADDR_W'(TOTAL - 2);

    AST_ONE_CYCLE_TAP: assert property (@(posedge clk) disable iff (!armed)
        en |=> (tap_addr != '0 || tap_out == $past(din))); // R1

    AST_STAGE_ADVANCE: assert property (@(posedge clk) disable iff (!armed)
        (en && tap_addr != TOP_A) |=>
        (tap_addr != $past(tap_addr) + ADDR_W'(1) || tap_out == $past(tap_out))); // R5

    AST_CASC_FOLLOW: assert property (@(posedge clk) disable iff (!armed)
        (en && tap_addr == PREV_A) |=> (casc_out == $past(tap_out))); // R4

    AST_IDLE_TAP_HOLD: assert property (@(posedge clk) disable iff (!armed)
        !en |=> (tap_addr != $past(tap_addr) || $stable(tap_out))); // R3

    AST_IDLE_CASC_HOLD: assert property (@(posedge clk) disable iff (!armed)
        !en |=> $stable(casc_out)); // R3

endmodule

bind vardelay_line vdl_chk #(
    .ADDR_W(ADDR_W),
    .TOTAL (TOTAL)
) u_chk (
    .clk     (clk),
    .en      (en),
    .din     (din),
    .tap_addr(tap_addr),
    .tap_out (tap_out),
    .casc_out(casc_out)
);

// File: tb/vardelay_line_tb.sv
`timescale 1ns/10ps
module vardelay_line_tb;

    localparam int N  = 128;
    localparam int AW = 7;

    logic          clk = 1'b0;
    logic          en = 1'b0;
    logic          din = 1'b0;
    logic [AW-1:0] tap_addr = '0;
    logic          tap_out;
    logic          casc_out;

    int total = 0;
    int fails = 0;
    int shifts = 0;
    logic [N-1:0] hist = '0;    // hist[k]: din bit from k+1 enabled edges ago
    logic [15:0] lf = 16'hACE1;

    always #2.5 clk = ~clk;

    vardelay_line u_dut (
        .clk(clk), .en(en), .din(din), .tap_addr(tap_addr),
        .tap_out(tap_out), .casc_out(casc_out)
    );

    // Expected contents, built only from the stimulus
    always @(posedge clk) begin
        if (en) begin
            hist   <= {hist[N-2:0], din};
            shifts <= shifts + 1;
        end
    end

    function automatic logic prbs();
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        return lf[0];
    endfunction

    task automatic check(input string req, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%b expected=%b (addr=%0d t=%0t)", req, act, exp, tap_addr, $time);
        end
    endtask

    // Drive one cycle at the falling edge, then sample before the rising edge
    task automatic cycle(input logic d, input logic e, input logic [AW-1:0] a);
        @(negedge clk);
        din = d; en = e; tap_addr = a;
        #1;
    endtask

    task automatic check_tap(input string req);
        if (shifts > int'(tap_addr)) check(req, tap_out, hist[tap_addr]);
    endtask

    task automatic t_fill();
        for (int i = 0; i < N + 8; i++) begin
            cycle(prbs(), 1'b1, '0);
            check_tap("R1 one-cycle delay at address 0");
        end
    endtask

    task automatic t_const_delay(input logic [AW-1:0] a, input int len);
        for (int i = 0; i < len; i++) begin
            cycle(prbs(), 1'b1, a);
            check_tap("R6 constant delay");
        end
    endtask

    task automatic t_limits();
        for (int i = 0; i < 20; i++) begin
            cycle(prbs(), 1'b1, 7'd0);
            check_tap("R7 minimum delay 1");
            #0.5 tap_addr = 7'd127;
            #0.5 check_tap("R7 maximum delay 128");
        end
    endtask

    task automatic t_wide();
        logic [AW-1:0] pts [8] = '{7'd31, 7'd32, 7'd63, 7'd64, 7'd95, 7'd96, 7'd100, 7'd126};
        for (int i = 0; i < 40; i++) begin
            cycle(prbs(), 1'b1, pts[i % 8]);
            check_tap("R5 unit select across boundaries");
        end
    endtask

    task automatic t_cascade();
        for (int i = 0; i < 40; i++) begin
            cycle(prbs(), 1'b1, 7'(i));
            if (shifts >= N) check("R4 cascade output delay 128", casc_out, hist[N-1]);
        end
    endtask

    task automatic t_live_addr();
        logic [AW-1:0] a;
        cycle(1'b0, 1'b0, '0);
        for (int i = 0; i < 32; i++) begin
            @(negedge clk);
            for (int j = 0; j < 4; j++) begin
                a = 7'(i * 4 + j);
                tap_addr = a;
                #0.5;
                check_tap("R2 live address change without edge");
            end
        end
    endtask

    task automatic t_hold();
        logic tap_before, casc_before;
        cycle(prbs(), 1'b1, 7'd45);
        cycle(1'b1, 1'b0, 7'd45);
        tap_before = tap_out; casc_before = casc_out;
        for (int i = 0; i < 8; i++) begin
            cycle(i[0], 1'b0, 7'd45);
            check("R3 tap held while disabled", tap_out, tap_before);
            check("R3 cascade held while disabled", casc_out, casc_before);
        end
        for (int i = 0; i < 30; i++) begin
            cycle(prbs(), 1'b1, 7'(i * 3));
            check_tap("R3 resumes after idle");
        end
    endtask

    initial begin
        #1000000;
        total++;
        fails++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        t_fill();
        t_const_delay(7'd16, 60);
        t_const_delay(7'd5, 30);
        t_const_delay(7'd31, 40);
        t_limits();
        t_wide();
        t_cascade();
        t_live_addr();
        t_hold();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule